// File: doc/BRIEF.md
# Synchronous Timeslot Transfer Controller

This block moves one byte per frame between a source location and a destination location of a TDM switching memory. It has two independent channels, A and B. Each channel has its own enable, source address, destination address and data register, and a processor can read or write each data register. A free-running frame counter divides time into frames of `FRAME_LEN` clocks. Once per frame the controller closes the processor access window. While the window is closed it performs the memory exchanges for the enabled channels. It then reopens the window and raises a start interrupt.

During the closed window, each enabled channel first reads its source location and then writes its previous data register contents to its destination location. The byte it read becomes the new data register contents. If the processor leaves a data register untouched, the byte received last frame is therefore echoed to the destination. An enabled channel whose register was neither read nor written while the window was open sets an overflow status bit at the moment the window closes.

The controller is a four-state machine:
- OPEN: the window is open.
- CHECK: one cycle. It samples the configuration and evaluates overflow.
- XFER_A: `SLOT_CYC` cycles serving channel A.
- XFER_B: `SLOT_CYC` cycles serving channel B.

The transitions are:
- OPEN goes to CHECK at the last count of the frame.
- CHECK goes to XFER_A if A is enabled, else to XFER_B if B is enabled, else to OPEN.
- XFER_A goes to XFER_B or OPEN after its last slot, depending on B's sampled enable.
- XFER_B goes to OPEN after its last slot.

Top module: `stx_sync_xfer`

## Requirements
- R1: `win_open` is 1 except for one closed window per frame. The window closes at the clock where the frame count wraps, so successive closings are exactly `FRAME_LEN` cycles apart. It stays low for 1 + `SLOT_CYC` × (number of enabled channels) cycles: 17 with one channel and 33 with both at the defaults.
- R2: Status bit 0 (start) is set in the same cycle that `win_open` returns to 1.
- R3: At the window closing, status bit 1 (channel A overflow) or bit 2 (channel B overflow) is set for each enabled channel whose data register saw no read or write while the window was open. A channel disabled at the closing never sets its overflow bit.
- R4: For each enabled channel, the memory is read at the source address in the first slot cycle. In the second slot cycle the old data register value is written to the destination address, and the byte read is loaded into the data register. Channel A is served before channel B. `mem_rdata` is expected one cycle after `mem_re`.
- R5: If the processor did not write a channel's data register, the byte that channel received in the previous transfer is written unchanged to the destination.
- R6: While the window is closed, processor writes are ignored. Reads return the value the register held when the window closed, and they do not count as accesses. `cpu_sel` = 0 selects channel A and 1 selects channel B.
- R7: `ch_en` (bit 0 = A, bit 1 = B) and the four address inputs are sampled only at the closing. Changes made earlier in the open window take effect at that closing.
- R8: Status bits are sticky until a one-cycle `sts_clr` strobe, after which `sts_o` reads 0.
- R9: `irq_o` is 1 exactly when some status bit is 1 and its `irq_mask` bit is 0.
- R10: After reset the window is open, status and `irq_o` are 0, data registers read 0, and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 2 | Channel enables, bit 0 = A, bit 1 = B |
| src_a | input | ADDR_W | Channel A source address |
| dst_a | input | ADDR_W | Channel A destination address |
| src_b | input | ADDR_W | Channel B source address |
| dst_b | input | ADDR_W | Channel B destination address |
| cpu_sel | input | 1 | Data register select, 0 = A, 1 = B |
| cpu_wr | input | 1 | Data register write strobe |
| cpu_rd | input | 1 | Data register read strobe |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data of the selected register |
| sts_clr | input | 1 | Status clear strobe |
| irq_mask | input | 3 | Per-bit interrupt mask, 1 = masked |
| sts_o | output | 3 | Status: bit 0 start, bit 1 A overflow, bit 2 B overflow |
| irq_o | output | 1 | Interrupt request |
| win_open | output | 1 | Processor access window open |
| mem_addr | output | ADDR_W | Switching memory address |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_re` |

## Verification
- **Window and status timing.** The closed window begins one edge after the last frame count, and `win_open`, the start bit and the overflow bits all become visible before the first open cycle. The bench therefore checks status and memory at the first negative edge where `win_open` is high again.
- **Closed-window length.** The bench measures the closed length by counting the negative edges at which `win_open` is low.
- **Processor reads.** The read data path is combinational, so reads are checked 1 ns after the strobe is driven at a negative edge.
- **Status clear.** The clear strobe takes effect on the following edge and is checked at the next negative edge.
- **Memory model.** The bench memory answers with one cycle of latency, matching R4. The expected memory image, data registers and overflow bits come from a bench model that applies A then B, each as a read followed by a write.

// File: rtl/stx_pkg.sv
package stx_pkg;
    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_XFER_A = 2'd2,
        ST_XFER_B = 2'd3
    } stx_state_e;

    localparam int unsigned NCH   = 2;
    localparam int unsigned STS_W = 3;
endpackage

// File: rtl/stx_frame_timer.sv
module stx_frame_timer #(
    parameter int unsigned FRAME_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    output logic frame_end
);
    localparam int unsigned CNT_W = $clog2(FRAME_LEN);

    logic [CNT_W-1:0] cnt_q;

    assign frame_end = (cnt_q == CNT_W'(FRAME_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (frame_end) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/stx_channel.sv
module stx_channel #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_open,
    input  logic              close_evt,
    input  logic              frozen,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] data_o,
    output logic [DATA_W-1:0] rd_o,
    output logic              acc_o
);
    logic [DATA_W-1:0] data_q, hold_q;
    logic              acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            hold_q <= '0;
            acc_q  <= 1'b0;
        end else begin
            if (load_en)                data_q <= load_data;
            else if (win_open && wr_stb) data_q <= wdata;
            if (!frozen) hold_q <= data_q;
            if (close_evt)                          acc_q <= 1'b0;
            else if (win_open && (wr_stb || rd_stb)) acc_q <= 1'b1;
        end
    end

    assign data_o = data_q;
    assign rd_o   = frozen ? hold_q : data_q;
    assign acc_o  = acc_q;

    // R6
    closed_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !load_en) |=> $stable(data_q));
endmodule

// File: rtl/stx_irq_status.sv
module stx_irq_status #(
    parameter int unsigned STS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] set_i,
    input  logic             clr_i,
    input  logic [STS_W-1:0] mask_i,
    output logic [STS_W-1:0] sts_o,
    output logic             irq_o
);
    logic [STS_W-1:0] sts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (clr_i ? '0 : sts_q) | set_i;
    end

    assign sts_o = sts_q;
    assign irq_o = |(sts_q & ~mask_i);

    // R8
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (set_i == '0)) |=> (sts_q == '0));

    // R8
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
endmodule

// File: rtl/stx_sync_xfer.sv
module stx_sync_xfer
    import stx_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 512,
    parameter int unsigned SLOT_CYC  = 16,
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ch_en,
    input  logic [ADDR_W-1:0] src_a,
    input  logic [ADDR_W-1:0] dst_a,
    input  logic [ADDR_W-1:0] src_b,
    input  logic [ADDR_W-1:0] dst_b,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              sts_clr,
    input  logic [2:0]        irq_mask,
    output logic [2:0]        sts_o,
    output logic              irq_o,
    output logic              win_open,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int unsigned SLOT_W = $clog2(SLOT_CYC);

    stx_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [NCH-1:0]    en_q, acc_w, wr_stb, rd_stb, load_en;
    logic [ADDR_W-1:0] src_q [NCH];
    logic [ADDR_W-1:0] dst_q [NCH];
    logic [DATA_W-1:0] data_w [NCH];
    logic [DATA_W-1:0] rd_w [NCH];
    logic              frame_end, in_xfer, slot_last, ch_idx, close_evt;
    logic [STS_W-1:0]  sts_set;

    stx_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (frame_end) state_d = ST_CHECK;
            ST_CHECK:  state_d = ch_en[0] ? ST_XFER_A : (ch_en[1] ? ST_XFER_B : ST_OPEN);
            ST_XFER_A: if (slot_last) state_d = en_q[1] ? ST_XFER_B : ST_OPEN;
            ST_XFER_B: if (slot_last) state_d = ST_OPEN;
            default:   state_d = ST_OPEN;
        endcase
    end

    // slot counter and configuration snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            en_q   <= '0;
            for (int i = 0; i < NCH; i++) begin
                src_q[i] <= '0;
                dst_q[i] <= '0;
            end
        end else begin
            if (in_xfer && !slot_last) slot_q <= slot_q + 1'b1;
            else                       slot_q <= '0;
            if (close_evt) begin
                en_q     <= ch_en;
                src_q[0] <= src_a;
                dst_q[0] <= dst_a;
                src_q[1] <= src_b;
                dst_q[1] <= dst_b;
            end
        end
    end

    // outputs of the state machine
    always_comb begin
        win_open  = (state_q == ST_OPEN);
        close_evt = (state_q == ST_CHECK);
        in_xfer   = (state_q == ST_XFER_A) || (state_q == ST_XFER_B);
        ch_idx    = (state_q == ST_XFER_B);
        slot_last = (slot_q == SLOT_W'(SLOT_CYC - 1));
        mem_re    = in_xfer && (slot_q == '0);
        mem_we    = in_xfer && (slot_q == SLOT_W'(1));
        mem_addr  = mem_re ? src_q[ch_idx] : dst_q[ch_idx];
        mem_wdata = data_w[ch_idx];
        sts_set[0]   = (state_q != ST_OPEN) && (state_d == ST_OPEN);
        sts_set[2:1] = close_evt ? (ch_en & ~acc_w) : 2'b00;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_stb[i]  = cpu_wr && (cpu_sel == 1'(i));
        assign rd_stb[i]  = cpu_rd && (cpu_sel == 1'(i));
        assign load_en[i] = mem_we && (ch_idx == 1'(i));

        stx_channel #(.DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .win_open(win_open), .close_evt(close_evt),
            .frozen(in_xfer), .wr_stb(wr_stb[i]), .rd_stb(rd_stb[i]), .wdata(cpu_wdata),
            .load_en(load_en[i]), .load_data(mem_rdata), .data_o(data_w[i]),
            .rd_o(rd_w[i]), .acc_o(acc_w[i])
        );
    end

    assign cpu_rdata = rd_w[cpu_sel];

    stx_irq_status #(.STS_W(STS_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(sts_set), .clr_i(sts_clr),
        .mask_i(irq_mask), .sts_o(sts_o), .irq_o(irq_o)
    );

    // R4
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_re));

    // R2
    start_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> sts_o[0]);

    // R3
    ovf_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (close_evt && !ch_en[0]) |=> !$rose(sts_o[1]));

    // R7
    xfer_b_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER_B) |-> en_q[1]);
endmodule

// File: tb/stx_sync_xfer_tb.sv
`timescale 1ns/1ps
module stx_sync_xfer_tb_top;
    localparam int FRAME_LEN = 512;
    localparam int SLOT_CYC  = 16;
    localparam int ADDR_W    = 9;
    localparam int DATA_W    = 8;
    localparam int MEM_N     = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] ch_en = '0;
    logic [ADDR_W-1:0] src_a = '0, dst_a = '0, src_b = '0, dst_b = '0;
    logic cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0, sts_clr = 1'b0;
    logic [DATA_W-1:0] cpu_wdata = '0, cpu_rdata;
    logic [2:0] irq_mask = '0, sts_o;
    logic irq_o, win_open, mem_re, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    logic [DATA_W-1:0] mem_dut [MEM_N];
    logic [DATA_W-1:0] mem_exp [MEM_N];
    logic [DATA_W-1:0] exp_data [2];
    int checks = 0, errors = 0, cyc = 0;

    always #2.5 clk = ~clk;

    stx_sync_xfer #(.FRAME_LEN(FRAME_LEN), .SLOT_CYC(SLOT_CYC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .src_a(src_a), .dst_a(dst_a), .src_b(src_b),
        .dst_b(dst_b), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .sts_clr(sts_clr), .irq_mask(irq_mask), .sts_o(sts_o), .irq_o(irq_o),
        .win_open(win_open), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_re) mem_rdata <= mem_dut[mem_addr];
        if (mem_we) mem_dut[mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int closed_len(input logic [1:0] en);
        return 1 + SLOT_CYC * (int'(en[0]) + int'(en[1]));
    endfunction

    function automatic logic irq_model(input logic [2:0] s, input logic [2:0] m);
        return |(s & ~m);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] en_f, acc;
        logic [2:0] exp_sts, mask;
        logic [DATA_W-1:0] pre0, tmp;
        int act, ncl, last_close, mism;
        logic [DATA_W-1:0] val;
        void'($urandom(32'd1357));
        for (int i = 0; i < MEM_N; i++) begin
            mem_dut[i] = 8'($urandom);
            mem_exp[i] = mem_dut[i];
        end
        exp_data[0] = '0; exp_data[1] = '0;
        last_close = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(win_open == 1'b1, "R10", "win_open", win_open, 1);
        chk(sts_o == 3'b000 && irq_o == 1'b0, "R10", "status/irq", sts_o, 0);
        chk(cpu_rdata == '0, "R10", "rdata", cpu_rdata, 0);
        chk(!mem_re && !mem_we, "R10", "mem idle", {mem_re, mem_we}, 0);

        for (int f = 0; f < 28; f++) begin
            acc = 2'b00;
            mask = 3'($urandom);
            irq_mask = mask;
            for (int ch = 0; ch < 2; ch++) begin
                act = (f == 0) ? 0 : (f == 1) ? 2 : (f == 2) ? 1 : int'($urandom % 3);
                cpu_sel = 1'(ch);
                if (act == 1) begin
                    cpu_rd = 1'b1; #1;
                    // R4: register holds the byte read last transfer
                    chk(cpu_rdata == exp_data[ch], "R4", "open read", cpu_rdata, exp_data[ch]);
                    @(negedge clk); cpu_rd = 1'b0;
                    acc[ch] = 1'b1;
                end else if (act == 2) begin
                    val = 8'($urandom);
                    cpu_wdata = val; cpu_wr = 1'b1;
                    @(negedge clk); cpu_wr = 1'b0;
                    exp_data[ch] = val;
                    acc[ch] = 1'b1;
                end
            end
            en_f = (f == 0) ? 2'b11 : (f == 1) ? 2'b01 : (f == 2) ? 2'b10 : (f == 3) ? 2'b00 : 2'($urandom);
            // R7: wrong values first, final values before the closing
            ch_en = ~en_f;
            src_a = ADDR_W'($urandom); dst_a = ADDR_W'($urandom);
            src_b = ADDR_W'($urandom); dst_b = ADDR_W'($urandom);
            repeat (3) @(negedge clk);
            ch_en = en_f;
            src_a = ADDR_W'($urandom); dst_a = ADDR_W'($urandom);
            src_b = ADDR_W'($urandom); dst_b = ADDR_W'($urandom);
            if (f == 4 || f == 9) src_b = dst_a;
            if (f == 6) dst_a = src_a;

            while (win_open) @(negedge clk);
            if (last_close >= 0)
                chk(cyc - last_close == FRAME_LEN, "R1", "frame period", cyc - last_close, FRAME_LEN);
            last_close = cyc;
            // R6: closed-window write and read on channel A
            pre0 = exp_data[0];
            cpu_sel = 1'b0; cpu_wr = 1'b1; cpu_rd = 1'b1; cpu_wdata = ~pre0;
            ncl = 0; mism = 0;
            while (!win_open) begin
                #1;
                if (cpu_rdata != pre0) mism++;
                ncl++;
                @(negedge clk);
            end
            cpu_wr = 1'b0; cpu_rd = 1'b0;
            chk(mism == 0, "R6", "closed read hold", mism, 0);
            chk(ncl == closed_len(en_f), "R1", "closed length", ncl, closed_len(en_f));

            for (int ch = 0; ch < 2; ch++) begin
                if (en_f[ch]) begin
                    tmp = mem_exp[ch == 0 ? src_a : src_b];
                    mem_exp[ch == 0 ? dst_a : dst_b] = exp_data[ch];
                    exp_data[ch] = tmp;
                end
            end
            exp_sts = {en_f & ~acc, 1'b1};
            chk(sts_o == exp_sts, "R2 R3", "status at open", sts_o, exp_sts);
            chk(irq_o == irq_model(exp_sts, mask), "R9", "irq", irq_o, irq_model(exp_sts, mask));
            mism = 0;
            for (int i = 0; i < MEM_N; i++) if (mem_dut[i] !== mem_exp[i]) mism++;
            chk(mism == 0, "R4 R5", "memory image", mism, 0);
            // R6: the closed-window write must not reach channel A
            cpu_sel = 1'b0; #1;
            chk(cpu_rdata == exp_data[0], "R6", "A after closed write", cpu_rdata, exp_data[0]);
            repeat (3) @(negedge clk);
            chk(sts_o == exp_sts, "R8", "sticky", sts_o, exp_sts);
            sts_clr = 1'b1;
            @(negedge clk); sts_clr = 1'b0;
            chk(sts_o == 3'b000, "R8", "cleared", sts_o, 0);
            chk(irq_o == 1'b0, "R9", "irq after clear", irq_o, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule